// File: doc/BRIEF.md
# Root Port Error Signalling Controller

This block holds the root port's 16-bit control word and the logic that acts on it. The control word decides which received error reports cause a system-error (SERR) pulse and whether power-management event (PME) messages cause an interrupt. Error reports arrive as single-cycle strobes, one per severity: correctable, non-fatal uncorrectable and fatal. An error can come from the root port itself or from any device below it.

The PME interrupt has two triggers. It fires when a PME message arrives while the interrupt is enabled. It also fires when software turns the enable on while the PME status input from the root status register already shows a pending event. The severity enables act alone: no generic command-register SERR enable gates them. The control word is read and written through a plain configuration port with two byte lanes.

Top module: `rp_err_signal`

## Requirements
- R1: After a synchronous active-low reset, the control word reads 0000h, and `serr_pulse` and `pme_irq` are both low.
- R2: `cfg_rdata[15:4]` always reads zero.
- R3: A write updates bits 3:0 only when `cfg_be[0]` is 1. A write with `cfg_be[0]` equal to 0 leaves the control word unchanged, whatever `cfg_be[1]` and the data are.
- R4: Bit 0 enables SERR for correctable errors (`err_cor`), bit 1 for non-fatal errors (`err_nonfatal`) and bit 2 for fatal errors (`err_fatal`). A strobe whose bit is clear gives no SERR. A strobe whose bit is set gives SERR, and no other enable gates it.
- R5: When strobes of several severities arrive in one cycle, the block issues exactly one single-cycle SERR pulse if at least one of them is enabled.
- R6: Bit 3 is the PME interrupt enable. While it is 1, every `pme_msg` strobe gives a PME interrupt pulse. While it is 0, `pme_msg` gives none.
- R7: A write that changes bit 3 from 0 to 1 while `pme_status` is 1 gives one PME interrupt pulse. Writing 1 to bit 3 when it is already 1 gives none.
- R8: `serr_pulse` and `pme_irq` are registered. Each is high for the single cycle after the triggering strobe or write. A strobe in the same cycle as a write is judged against the control word held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_be | input | 2 | Byte enables; bit 0 is the low byte, bit 1 the high byte |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Current control word; reserved bits read zero |
| err_cor | input | 1 | Correctable error report strobe |
| err_nonfatal | input | 1 | Non-fatal uncorrectable error report strobe |
| err_fatal | input | 1 | Fatal error report strobe |
| pme_msg | input | 1 | PME message received strobe |
| pme_status | input | 1 | PME status bit from the root status register |
| serr_pulse | output | 1 | System-error pulse |
| pme_irq | output | 1 | PME interrupt pulse |

## Verification
The assertions check these rules on every cycle:
- the reserved read bits stay zero;
- a write without the low byte enable leaves the word unchanged;
- SERR follows one cycle after any enabled strobe and never after a masked one;
- no PME interrupt appears while there is neither a message nor a pending status, or while the enable is already held.

Some behaviour only the bench's scenarios can show:
- the exact encoding of each enable bit;
- the interrupt when the enable rises over a pending status;
- the old control word deciding a strobe that shares a cycle with a write;
- the reset values after activity.

// File: rtl/rpe_pkg.sv
// Package: shared widths and bit positions for the root port error
// signalling controller. Assumes a 16-bit control word with four live bits.
package rpe_pkg;
    localparam int RPE_REG_W   = 16;
    localparam int RPE_CTRL_W  = 4;
    localparam int RPE_SEV_N   = 3;
    localparam int RPE_BE_W    = RPE_REG_W / 8;
    // Bit positions; the severity order matches the error strobe vector
    localparam int SEV_COR     = 0;
    localparam int SEV_NONFAT  = 1;
    localparam int SEV_FATAL   = 2;
    localparam int PME_EN_BIT  = 3;
endpackage

// File: rtl/rpe_ctrl_reg.sv
// Module: rpe_ctrl_reg
// Holds the live bits of the control word. Only the low byte lane can
// write them; the high byte lane and the reserved bits ignore writes.
// Assumes CTRL_W <= 8, so all live bits sit in byte lane 0.
module rpe_ctrl_reg #(
    parameter int REG_W  = rpe_pkg::RPE_REG_W,
    parameter int CTRL_W = rpe_pkg::RPE_CTRL_W,
    localparam int BE_W  = REG_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_we,
    input  logic [BE_W-1:0]   wr_be,
    input  logic [REG_W-1:0]  wr_data,
    output logic [CTRL_W-1:0] ctrl_q
);
    logic lane0_wr;
    logic unused_wr_bits;

    // Purpose: a write reaches the live bits only through byte lane 0
    assign lane0_wr       = wr_we && wr_be[0];
    assign unused_wr_bits = ^{wr_be[BE_W-1:1], wr_data[REG_W-1:CTRL_W]};

    for (genvar b = 0; b < CTRL_W; b++) begin : g_bit
        // Purpose: one read/write control bit with synchronous reset to zero
        always_ff @(posedge clk) begin
            if (!rst_n)        ctrl_q[b] <= 1'b0;
            else if (lane0_wr) ctrl_q[b] <= wr_data[b];
        end
    end

    AST_LANE0_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_we && !wr_be[0]) |=> $stable(ctrl_q)); // R3
endmodule

// File: rtl/rpe_serr_gen.sv
// Module: rpe_serr_gen
// Masks the error strobes with the per-severity enables and registers one
// SERR pulse. Assumes the strobes are synchronous single-cycle pulses.
module rpe_serr_gen #(
    parameter int SEV_N = rpe_pkg::RPE_SEV_N
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEV_N-1:0] err_vec,
    input  logic [SEV_N-1:0] sev_en,
    output logic             serr_pulse
);
    logic any_hit;

    // Purpose: OR of all enabled severities, so several strobes in one cycle give one pulse
    assign any_hit = |(err_vec & sev_en);

    // Purpose: register the pulse one clock after the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) serr_pulse <= 1'b0;
        else        serr_pulse <= any_hit;
    end

    AST_SERR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_vec & sev_en) == '0) |=> !serr_pulse); // R4
    AST_SERR_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_vec & sev_en) != '0) |=> serr_pulse); // R5
endmodule

// File: rtl/rpe_pme_gen.sv
// Module: rpe_pme_gen
// Raises a PME interrupt pulse in two cases: a PME message arrives while the
// interrupt is enabled, or the enable is written from 0 to 1 while a PME is
// pending. The held enable is the previous value used for edge detection.
module rpe_pme_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic en_q,
    input  logic en_wr,
    input  logic en_wr_val,
    input  logic pme_msg,
    input  logic pme_pend,
    output logic pme_irq
);
    logic en_rise;
    logic fire;

    // Purpose: a write sets the enable while the held value is still clear
    assign en_rise = en_wr && en_wr_val && !en_q;
    // Purpose: combine the message trigger and the pending-on-enable trigger
    assign fire    = (pme_msg && en_q) || (en_rise && pme_pend);

    // Purpose: register the interrupt pulse one clock after its cause
    always_ff @(posedge clk) begin
        if (!rst_n) pme_irq <= 1'b0;
        else        pme_irq <= fire;
    end

    AST_PME_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!pme_msg && !pme_pend) |=> !pme_irq); // R6
    AST_PME_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !pme_msg) |=> !pme_irq); // R7
endmodule

// File: rtl/rp_err_signal.sv
// Module: rp_err_signal (top)
// Root port control word with the SERR and PME interrupt logic behind it.
// Assumes all strobes are synchronous to clk. The read data is the current word.
module rp_err_signal #(
    parameter int REG_W  = rpe_pkg::RPE_REG_W,
    parameter int CTRL_W = rpe_pkg::RPE_CTRL_W,
    parameter int SEV_N  = rpe_pkg::RPE_SEV_N,
    localparam int BE_W  = REG_W / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [BE_W-1:0]  cfg_be,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic             err_cor,
    input  logic             err_nonfatal,
    input  logic             err_fatal,
    input  logic             pme_msg,
    input  logic             pme_status,
    output logic             serr_pulse,
    output logic             pme_irq
);
    import rpe_pkg::*;

    logic [CTRL_W-1:0] ctrl_q;
    logic [SEV_N-1:0]  err_vec;

    // Purpose: gather the severity strobes in enable-bit order
    always_comb begin
        err_vec             = '0;
        err_vec[SEV_COR]    = err_cor;
        err_vec[SEV_NONFAT] = err_nonfatal;
        err_vec[SEV_FATAL]  = err_fatal;
    end

    // Purpose: read data is the live bits with the reserved bits held at zero
    assign cfg_rdata = {{(REG_W-CTRL_W){1'b0}}, ctrl_q};

    rpe_ctrl_reg #(.REG_W(REG_W), .CTRL_W(CTRL_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_we   (cfg_we),
        .wr_be   (cfg_be),
        .wr_data (cfg_wdata),
        .ctrl_q  (ctrl_q)
    );

    rpe_serr_gen #(.SEV_N(SEV_N)) u_serr (
        .clk        (clk),
        .rst_n      (rst_n),
        .err_vec    (err_vec),
        .sev_en     (ctrl_q[SEV_N-1:0]),
        .serr_pulse (serr_pulse)
    );

    rpe_pme_gen u_pme (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_q      (ctrl_q[PME_EN_BIT]),
        .en_wr     (cfg_we && cfg_be[0]),
        .en_wr_val (cfg_wdata[PME_EN_BIT]),
        .pme_msg   (pme_msg),
        .pme_pend  (pme_status),
        .pme_irq   (pme_irq)
    );

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[REG_W-1:CTRL_W] == '0); // R2
endmodule

// File: tb/sim_rp_err_signal.sv
// Bench for rp_err_signal: a vector table walked by one loop, then directed
// reset tests. Inputs change at negedge; outputs are checked at the next negedge.
module sim_rp_err_signal;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 23;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [1:0]  cfg_be;
    logic [15:0] cfg_wdata;
    logic [15:0] cfg_rdata;
    logic        err_cor, err_nonfatal, err_fatal, pme_msg, pme_status;
    logic        serr_pulse, pme_irq;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rp_err_signal u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .err_cor(err_cor),
        .err_nonfatal(err_nonfatal), .err_fatal(err_fatal), .pme_msg(pme_msg),
        .pme_status(pme_status), .serr_pulse(serr_pulse), .pme_irq(pme_irq)
    );

    // Vector layout: we, be[1:0], wdata[15:0], err{fat,nf,cor}, pme, pend,
    // then expected serr, irq and rdata after one clock
    localparam logic [41:0] TBL [0:NV-1] = '{
        {1'b0, 2'b00, 16'h0000, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000}, // R1 idle
        {1'b0, 2'b00, 16'h0000, 3'b001, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000}, // R4 cor masked
        {1'b1, 2'b01, 16'h0001, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0001}, // R3 low byte write
        {1'b0, 2'b00, 16'h0000, 3'b001, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0001}, // R4 cor enabled
        {1'b0, 2'b00, 16'h0000, 3'b010, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0001}, // R4 nf masked
        {1'b0, 2'b00, 16'h0000, 3'b100, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0001}, // R4 fatal masked
        {1'b1, 2'b10, 16'hFFFF, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0001}, // R3 high lane ignored
        {1'b1, 2'b11, 16'hFFF6, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0006}, // R2 reserved zero
        {1'b0, 2'b00, 16'h0000, 3'b001, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0006}, // R4 cor now masked
        {1'b0, 2'b00, 16'h0000, 3'b010, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0006}, // R4 nf enabled
        {1'b0, 2'b00, 16'h0000, 3'b100, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0006}, // R4 fatal enabled
        {1'b0, 2'b00, 16'h0000, 3'b111, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0006}, // R5 all at once
        {1'b0, 2'b00, 16'h0000, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0006}, // R6 pme while off
        {1'b1, 2'b01, 16'h000E, 3'b000, 1'b0, 1'b1, 1'b0, 1'b1, 16'h000E}, // R7 rise over pending
        {1'b1, 2'b01, 16'h000E, 3'b000, 1'b0, 1'b1, 1'b0, 1'b0, 16'h000E}, // R7 no second irq
        {1'b0, 2'b00, 16'h0000, 3'b000, 1'b1, 1'b0, 1'b0, 1'b1, 16'h000E}, // R6 pme while on
        {1'b0, 2'b00, 16'h0000, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 16'h000E}, // R8 single-cycle pulse
        {1'b1, 2'b01, 16'h0006, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0006}, // R6 disable
        {1'b1, 2'b01, 16'h000E, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 16'h000E}, // R7 rise, none pending
        {1'b1, 2'b00, 16'h0000, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 16'h000E}, // R3 no lanes
        {1'b1, 2'b01, 16'h0000, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000}, // R3 clear
        {1'b1, 2'b01, 16'h0008, 3'b000, 1'b1, 1'b1, 1'b0, 1'b1, 16'h0008}, // R7 rise with msg
        {1'b1, 2'b01, 16'h0007, 3'b111, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0007}  // R8 old word decides
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive_idle();
        cfg_we = 0; cfg_be = 0; cfg_wdata = 0;
        {err_fatal, err_nonfatal, err_cor} = 3'b000;
        pme_msg = 0; pme_status = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rst_n = 0;
        drive_idle();
        repeat (3) @(negedge clk);
        check("R1 rdata", cfg_rdata, 16'h0000);
        check("R1 serr", {15'd0, serr_pulse}, 16'd0);
        check("R1 irq", {15'd0, pme_irq}, 16'd0);
        rst_n = 1;

        for (int i = 0; i < NV; i++) begin
            logic [41:0] v;
            v = TBL[i];
            cfg_we = v[41]; cfg_be = v[40:39]; cfg_wdata = v[38:23];
            {err_fatal, err_nonfatal, err_cor} = v[22:20];
            pme_msg = v[19]; pme_status = v[18];
            @(negedge clk);
            check($sformatf("vec%0d serr R4/R5/R8", i), {15'd0, serr_pulse}, {15'd0, v[17]});
            check($sformatf("vec%0d irq R6/R7", i), {15'd0, pme_irq}, {15'd0, v[16]});
            check($sformatf("vec%0d rdata R2/R3", i), cfg_rdata, v[15:0]);
        end

        // Directed R1: reset after activity clears the word, and strobes during reset are ignored
        drive_idle();
        err_fatal = 1; pme_msg = 1; rst_n = 0;
        @(negedge clk);
        check("R1 reset rdata", cfg_rdata, 16'h0000);
        check("R1 reset serr", {15'd0, serr_pulse}, 16'd0);
        check("R1 reset irq", {15'd0, pme_irq}, 16'd0);
        drive_idle();
        rst_n = 1;
        // Directed R4: fatal strobe after reset is masked by the cleared enables
        err_fatal = 1;
        @(negedge clk);
        check("R4 post-reset fatal masked", {15'd0, serr_pulse}, 16'd0);
        drive_idle();
        @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule